// File: doc/BRIEF.md
# Coprocessor access permission register

This block holds a 32-bit system control word that governs use of two floating-point/vector coprocessor slots, numbered 10 and 11. It also holds one flag that turns off SIMD-only instructions. Software reads and writes the word through a simple register port. Every port access carries the caller's exception level, its security state and a two-bit non-secure access control value. An access from EL0 is refused and flagged as undefined. When the caller is non-secure and the access control value is `00`, the two rights fields are closed: they read as zero and a write leaves them as they are.

Beside the register sits a combinational permission checker. The instruction decoder gives it a request with these parts: which slot the instruction targets, the exception level, whether the core is in Hyp mode, and whether the instruction is SIMD-only or floating-point. The checker answers with either allow or undefined-instruction. Both slots are judged by the slot 10 rights, even when software has stored a different value in the slot 11 field. After the rights check, a second gate applies the SIMD-disable flag. Instructions issued in Hyp mode are always allowed.

The security state input `reg_nonsec` is shared by the register port and the checker. The checker therefore sees the same closed-field view that a read at that moment would return.

Top module: `copr_access_ctl`

## Requirements
- R1: After reset, a privileged secure read returns 0x0000_0000, and every non-Hyp request is answered undefined.
- R2: Only bit 31 and bits [23:20] can ever read as 1. Written ones in any other bit are dropped.
- R3: Bit 31 is the SIMD-disable flag, bits [23:22] hold the slot 11 rights and bits [21:20] hold the slot 10 rights. A privileged write is stored at the next rising clock edge. Reads are combinational.
- R4: Rights encoding. `00` denies every request. `01` allows only requests from EL1 or higher, so EL0 is undefined. `11` allows requests from any level.
- R5: The reserved rights encoding `10` is treated as deny at every level.
- R6: Requests for both slots are judged by the slot 10 rights field. A read still returns the slot 11 value as stored.
- R7: When bit 31 is 1, a request marked SIMD-only is undefined and a floating-point request is judged by the rights alone. A request passes only if both the rights check and the SIMD check allow it.
- R8: A request with the Hyp flag set is allowed, whatever the register holds.
- R9: A read or write strobe at EL0 raises `reg_undef` in the same cycle. Such a write changes nothing, and such a read returns 0.
- R10: With `reg_nonsec`=1 and `reg_nsac`=`00`, the rights fields read as 0, a write leaves them unchanged while bit 31 is still written, and the checker treats the rights as `00`.
- R11: `chk_allow` and `chk_undef` are both 0 while `chk_valid` is 0. While it is 1, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_el | input | 2 | Exception level of the register access (0 = EL0) |
| reg_nonsec | input | 1 | Current security state, 1 = non-secure; used by the port and the checker |
| reg_nsac | input | 2 | Non-secure access control value; `00` closes the rights fields |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Masked read data; 0 when no privileged read |
| reg_undef | output | 1 | Register access attempted from EL0 |
| chk_valid | input | 1 | Permission request present |
| chk_cp | input | 1 | Target slot: 0 = coprocessor 10, 1 = coprocessor 11 |
| chk_el | input | 2 | Exception level of the request |
| chk_hyp | input | 1 | Request issued in Hyp mode |
| chk_simd | input | 1 | 1 = SIMD-only instruction, 0 = floating-point |
| chk_allow | output | 1 | Request may execute |
| chk_undef | output | 1 | Request raises undefined-instruction |

## Verification
A wrong stored bit shows at the ports in the cycle right after the write edge. It appears on a privileged read, and in the verdict of the checker on the next request, because both paths are combinational from the state. A fault in the closed-field gate shows only when the port is put into the non-secure, `00` condition. The bench therefore reads in both security states before and after each gated write. It uses this to tell a masked read apart from a lost write. Because slot 11 follows slot 10, a bad select shows only when the two fields hold different values. The bench stores such pairs deliberately.

// File: rtl/copr_pkg.sv
package copr_pkg;

   localparam int unsigned EL_W = 2;

   typedef logic [EL_W-1:0] el_t;

   localparam el_t EL_USER = 2'd0;

   typedef enum logic [1:0] {
      RIGHTS_NONE = 2'b00,
      RIGHTS_PRIV = 2'b01,
      RIGHTS_RSVD = 2'b10,
      RIGHTS_FULL = 2'b11
   } rights_e;

   function automatic logic el_is_priv(input el_t el);
      return el != EL_USER;
   endfunction

endpackage

// File: rtl/copr_ns_gate.sv
module copr_ns_gate #(
   parameter int unsigned NSAC_W = 2
) (
   input  logic              nonsec,
   input  logic [NSAC_W-1:0] nsac,
   output logic              fields_open
);

   if (NSAC_W < 1) begin : g_bad_w
      $error("copr_ns_gate: NSAC_W must be at least 1");
   end

   always_comb begin
      fields_open = 1'b1;
      if (nonsec && (nsac == '0)) begin
         fields_open = 1'b0;
      end
   end

endmodule

// File: rtl/copr_cfg_reg.sv
module copr_cfg_reg #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SIMD_BIT  = 31,
   parameter int unsigned N_SLOT    = 2,
   parameter int unsigned FIELD_W   = 2,
   parameter int unsigned SLOT_LSB0 = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fields_open,
   output logic [DATA_W-1:0] view
);

   localparam int unsigned FIELDS_W = N_SLOT * FIELD_W;
   localparam int unsigned FIELDS_HI = SLOT_LSB0 + FIELDS_W - 1;

   function automatic logic [DATA_W-1:0] make_field_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < int'(FIELDS_W); i++) begin
         m[SLOT_LSB0 + i] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [DATA_W-1:0] make_simd_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      m[SIMD_BIT] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] FIELD_MASK = make_field_mask();
   localparam logic [DATA_W-1:0] SIMD_MASK  = make_simd_mask();
   localparam logic [DATA_W-1:0] LIVE_MASK  = FIELD_MASK | SIMD_MASK;

   if (FIELDS_HI >= DATA_W) begin : g_bad_fields
      $error("copr_cfg_reg: rights fields exceed the data width");
   end
   if (SIMD_BIT >= DATA_W) begin : g_bad_simd
      $error("copr_cfg_reg: SIMD bit outside the data width");
   end
   if ((SIMD_BIT >= SLOT_LSB0) && (SIMD_BIT <= FIELDS_HI)) begin : g_overlap
      $error("copr_cfg_reg: SIMD bit overlaps a rights field");
   end

   logic [DATA_W-1:0] store_q;
   logic [DATA_W-1:0] wr_mask;
   logic [DATA_W-1:0] rd_mask;

   always_comb begin
      wr_mask = fields_open ? LIVE_MASK : SIMD_MASK;
      rd_mask = fields_open ? LIVE_MASK : SIMD_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else if (wr_fire) begin
         store_q <= (wdata & wr_mask) | (store_q & ~wr_mask);
      end
   end

   assign view = store_q & rd_mask;

endmodule

// File: rtl/copr_rights_dec.sv
module copr_rights_dec
   import copr_pkg::*;
(
   input  rights_e rights,
   input  el_t     el,
   output logic    allow
);

   always_comb begin
      unique case (rights)
         RIGHTS_NONE: allow = 1'b0;
         RIGHTS_PRIV: allow = el_is_priv(el);
         RIGHTS_RSVD: allow = 1'b0;
         RIGHTS_FULL: allow = 1'b1;
         default:     allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/copr_perm_check.sv
module copr_perm_check
   import copr_pkg::*;
#(
   parameter int unsigned N_SLOT       = 2,
   parameter int unsigned FIELD_W      = 2,
   parameter bit          FOLLOW_SLOT0 = 1'b1,
   localparam int unsigned SEL_W       = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input  logic                      valid,
   input  logic [SEL_W-1:0]          cp_sel,
   input  el_t                       el,
   input  logic                      hyp,
   input  logic                      simd_only,
   input  logic                      simd_dis,
   input  logic [N_SLOT*FIELD_W-1:0] rights,
   output logic                      allow,
   output logic                      undef
);

   if (FIELD_W != 2) begin : g_bad_fw
      $error("copr_perm_check: rights decode needs FIELD_W of 2");
   end

   logic [FIELD_W-1:0] sel_rights;
   logic               rights_ok;
   logic               simd_ok;
   logic               pass;

   if (FOLLOW_SLOT0) begin : g_follow
      logic unused_sel;
      assign unused_sel = ^{cp_sel, rights};
      assign sel_rights = rights[0 +: FIELD_W];
   end else begin : g_own
      logic [FIELD_W-1:0] slot_r [N_SLOT];
      for (genvar s = 0; s < int'(N_SLOT); s++) begin : g_slot
         assign slot_r[s] = rights[s*FIELD_W +: FIELD_W];
      end
      always_comb begin
         sel_rights = slot_r[0];
         for (int s = 0; s < int'(N_SLOT); s++) begin
            if (cp_sel == SEL_W'(s)) sel_rights = slot_r[s];
         end
      end
   end

   copr_rights_dec u_dec (
      .rights (rights_e'(sel_rights)),
      .el     (el),
      .allow  (rights_ok)
   );

   assign simd_ok = !(simd_dis && simd_only);

   always_comb begin
      pass = hyp || (rights_ok && simd_ok);
      allow = valid && pass;
      undef = valid && !pass;
   end

endmodule

// File: rtl/copr_access_ctl.sv
module copr_access_ctl
   import copr_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned SIMD_BIT     = 31,
   parameter int unsigned N_SLOT       = 2,
   parameter int unsigned FIELD_W      = 2,
   parameter int unsigned SLOT_LSB0    = 20,
   parameter int unsigned NSAC_W       = 2,
   parameter bit          FOLLOW_SLOT0 = 1'b1,
   localparam int unsigned SEL_W       = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [1:0]        reg_el,
   input  logic              reg_nonsec,
   input  logic [NSAC_W-1:0] reg_nsac,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_undef,
   input  logic              chk_valid,
   input  logic [SEL_W-1:0]  chk_cp,
   input  logic [1:0]        chk_el,
   input  logic              chk_hyp,
   input  logic              chk_simd,
   output logic              chk_allow,
   output logic              chk_undef
);

   localparam int unsigned FIELDS_W = N_SLOT * FIELD_W;

   if (N_SLOT < 1) begin : g_bad_slots
      $error("copr_access_ctl: N_SLOT must be at least 1");
   end

   logic              port_priv;
   logic              fields_open;
   logic              wr_fire;
   logic [DATA_W-1:0] view;

   assign port_priv = el_is_priv(el_t'(reg_el));
   assign wr_fire   = reg_wr_en && port_priv;
   assign reg_undef = (reg_wr_en || reg_rd_en) && !port_priv;
   assign reg_rdata = (reg_rd_en && port_priv) ? view : '0;

   copr_ns_gate #(.NSAC_W(NSAC_W)) u_gate (
      .nonsec      (reg_nonsec),
      .nsac        (reg_nsac),
      .fields_open (fields_open)
   );

   copr_cfg_reg #(
      .DATA_W    (DATA_W),
      .SIMD_BIT  (SIMD_BIT),
      .N_SLOT    (N_SLOT),
      .FIELD_W   (FIELD_W),
      .SLOT_LSB0 (SLOT_LSB0)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_fire     (wr_fire),
      .wdata       (reg_wdata),
      .fields_open (fields_open),
      .view        (view)
   );

   copr_perm_check #(
      .N_SLOT       (N_SLOT),
      .FIELD_W      (FIELD_W),
      .FOLLOW_SLOT0 (FOLLOW_SLOT0)
   ) u_chk_logic (
      .valid     (chk_valid),
      .cp_sel    (chk_cp),
      .el        (el_t'(chk_el)),
      .hyp       (chk_hyp),
      .simd_only (chk_simd),
      .simd_dis  (view[SIMD_BIT]),
      .rights    (view[SLOT_LSB0 +: FIELDS_W]),
      .allow     (chk_allow),
      .undef     (chk_undef)
   );

endmodule

// File: rtl/copr_access_chk.sv
module copr_access_chk #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned SIMD_BIT     = 31,
   parameter int unsigned N_SLOT       = 2,
   parameter int unsigned FIELD_W      = 2,
   parameter int unsigned SLOT_LSB0    = 20,
   parameter int unsigned NSAC_W       = 2,
   parameter bit          FOLLOW_SLOT0 = 1'b1,
   localparam int unsigned SEL_W       = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic              reg_rd_en,
   input logic [1:0]        reg_el,
   input logic              reg_nonsec,
   input logic [NSAC_W-1:0] reg_nsac,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              reg_undef,
   input logic              chk_valid,
   input logic [SEL_W-1:0]  chk_cp,
   input logic [1:0]        chk_el,
   input logic              chk_hyp,
   input logic              chk_simd,
   input logic              chk_allow,
   input logic              chk_undef
);

   logic [DATA_W-1:0] live;
   logic [DATA_W-1:0] flds;
   always_comb begin
      flds = '0;
      for (int i = 0; i < int'(N_SLOT * FIELD_W); i++) flds[SLOT_LSB0 + i] = 1'b1;
      live = flds;
      live[SIMD_BIT] = 1'b1;
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~live) == '0); // R2

   AST_SIMD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_el != 2'd0) |=>
         (!reg_rd_en || reg_el == 2'd0 || reg_rdata[SIMD_BIT] == $past(reg_wdata[SIMD_BIT]))); // R3

   AST_HYP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_hyp) |-> chk_allow); // R8

   AST_EL0_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr_en || reg_rd_en) && reg_el == 2'd0) |-> (reg_undef && reg_rdata == '0)); // R9

   AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_nonsec && reg_nsac == '0) |-> ((reg_rdata & flds) == '0)); // R10

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid ? $onehot({chk_allow, chk_undef}) : !(chk_allow || chk_undef)); // R11

   logic unused_in;
   assign unused_in = ^{chk_cp, chk_el, chk_simd};

endmodule

bind copr_access_ctl copr_access_chk #(
   .DATA_W       (DATA_W),
   .SIMD_BIT     (SIMD_BIT),
   .N_SLOT       (N_SLOT),
   .FIELD_W      (FIELD_W),
   .SLOT_LSB0    (SLOT_LSB0),
   .NSAC_W       (NSAC_W),
   .FOLLOW_SLOT0 (FOLLOW_SLOT0)
) u_access_chk (.*);

// File: tb/copr_access_ctl_tb.sv
module copr_access_ctl_tb;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic        reg_rd_en = 1'b0;
   logic [1:0]  reg_el = 2'd1;
   logic        reg_nonsec = 1'b0;
   logic [1:0]  reg_nsac = 2'b11;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_undef;
   logic        chk_valid = 1'b0;
   logic        chk_cp = 1'b0;
   logic [1:0]  chk_el = 2'd0;
   logic        chk_hyp = 1'b0;
   logic        chk_simd = 1'b0;
   logic        chk_allow;
   logic        chk_undef;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   copr_access_ctl u_dut (.*);

   task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] d, input logic [1:0] el,
                           input logic ns, input logic [1:0] nsac, output logic undef);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wdata = d; reg_el = el; reg_nonsec = ns; reg_nsac = nsac;
      #1 undef = reg_undef;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] el, input logic ns, input logic [1:0] nsac,
                          output logic [31:0] d, output logic undef);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_el = el; reg_nonsec = ns; reg_nsac = nsac;
      #1 d = reg_rdata; undef = reg_undef;
      reg_rd_en = 1'b0;
   endtask

   // result encoding: {allow, undef}
   task automatic ask(input logic cp, input logic [1:0] el, input logic hyp, input logic simd,
                      input logic ns, input logic [1:0] nsac, input logic exp_allow,
                      input string tag);
      @(negedge clk);
      chk_valid = 1'b1; chk_cp = cp; chk_el = el; chk_hyp = hyp; chk_simd = simd;
      reg_nonsec = ns; reg_nsac = nsac;
      #1 expect32(tag, {30'd0, chk_allow, chk_undef}, {30'd0, exp_allow, !exp_allow});
      chk_valid = 1'b0;
   endtask

   task automatic wr_ok(input logic [31:0] d);
      logic u;
      do_write(d, 2'd1, 1'b0, 2'b11, u);
   endtask

   task automatic rd_expect(input logic [31:0] exp, input string tag);
      logic [31:0] d; logic u;
      do_read(2'd1, 1'b0, 2'b11, d, u);
      expect32(tag, d, exp);
   endtask

   task automatic t_reset;
      rd_expect(32'h0000_0000, "R1 reset readback");
      ask(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R1 reset denies cp10 EL3");
      @(negedge clk);
      chk_valid = 1'b0; chk_hyp = 1'b1;
      #1 expect32("R11 idle verdict", {30'd0, chk_allow, chk_undef}, 32'd0);
      chk_hyp = 1'b0;
   endtask

   task automatic t_masking;
      wr_ok(32'hFFFF_FFFF);
      rd_expect(32'h80F0_0000, "R2 reserved bits dropped");
      wr_ok(32'h7F0F_FFFF);
      rd_expect(32'h0000_0000, "R3 fields cleared by write");
   endtask

   task automatic t_rights;
      wr_ok(32'h0050_0000);
      rd_expect(32'h0050_0000, "R3 priv rights readback");
      ask(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R4 01 denies EL0");
      ask(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R4 01 allows EL1");
      wr_ok(32'h00F0_0000);
      ask(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R4 11 allows EL0");
      wr_ok(32'h00A0_0000);
      ask(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R5 10 denies EL3");
   endtask

   task automatic t_follow;
      wr_ok(32'h0030_0000);
      rd_expect(32'h0030_0000, "R6 slot11 own readback");
      ask(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R6 slot11 uses slot10 full");
      wr_ok(32'h00C0_0000);
      ask(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, "R6 slot11 uses slot10 none");
   endtask

   task automatic t_simd;
      wr_ok(32'h8030_0000);
      ask(1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, "R7 SIMD-only blocked");
      ask(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R7 FP still allowed");
      ask(1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, "R8 hyp overrides SIMD");
      wr_ok(32'h0000_0000);
      ask(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, "R8 hyp overrides rights");
   endtask

   task automatic t_el0;
      logic u; logic [31:0] d;
      wr_ok(32'h8030_0000);
      do_write(32'h0000_0000, 2'd0, 1'b0, 2'b11, u);
      expect32("R9 EL0 write flagged", {31'd0, u}, 32'd1);
      rd_expect(32'h8030_0000, "R9 EL0 write no effect");
      do_read(2'd0, 1'b0, 2'b11, d, u);
      expect32("R9 EL0 read zero", d, 32'd0);
      expect32("R9 EL0 read flagged", {31'd0, u}, 32'd1);
   endtask

   task automatic t_nonsec;
      logic u; logic [31:0] d;
      do_read(2'd1, 1'b1, 2'b00, d, u);
      expect32("R10 closed fields read zero", d, 32'h8000_0000);
      ask(1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, "R10 closed rights deny");
      ask(1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, "R10 open nonsec allows");
      do_write(32'h00C0_0000, 2'd1, 1'b1, 2'b00, u);
      rd_expect(32'h0030_0000, "R10 closed write keeps fields");
      do_write(32'h00C0_0000, 2'd1, 1'b1, 2'b10, u);
      rd_expect(32'h00C0_0000, "R10 open nonsec write lands");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_masking;
      t_rights;
      t_follow;
      t_simd;
      t_el0;
      t_nonsec;
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule